// File: doc/BRIEF.md
# Clocked Controller for an Asynchronous Static RAM

This block lets a synchronous system read and write one external asynchronous static RAM of 131,072 bytes (17-bit address, 8-bit word). The system hands it single-word requests on a valid/ready handshake. The controller drives the address, an active-low chip select, an active-low write enable and an active-low output enable. It also owns one side of the shared bidirectional byte bus.

Each phase of an access is held for a whole number of clock cycles. That number is worked out at elaboration from a clock-period parameter in picoseconds and the memory's minimum timing figures (ceiling of time over period, never less than one cycle), so the memory's limits hold at any clock rate.

A finite-state machine steps through five named states:
- `ST_IDLE`: accepts a request.
- `ST_WR_PULSE`: write strobe low, bus driven.
- `ST_WR_RECOV`: strobes high, address still held.
- `ST_RD_ACCESS`: chip select and output enable low.
- `ST_RD_HOLD`: strobes high while the memory releases the bus.

The transitions are:
- idle→write-pulse on an accepted write.
- idle→read-access on an accepted read.
- write-pulse→write-recovery when the pulse count runs out.
- read-access→read-hold when the access count runs out; read data is captured on this edge.
- write-recovery→idle and read-hold→idle when their counts run out.

Top module: `sram_port_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `sram_cs_n`, `sram_we_n` and `sram_oe_n` are 1, and `rsp_valid` is 0.
- R2: With period P ps, the phase lengths in cycles are as follows. Write pulse is max(⌈12000/P⌉, ⌈8000/P⌉, 1). Write recovery is max(⌈2000/P⌉, ⌈15000/P⌉ − pulse, 1). Read access is max(⌈15000/P⌉, 1). Read hold is max(⌈8000/P⌉, 1). For P = 4000 these give 3, 1, 4 and 2.
- R3: A write holds `sram_cs_n` and `sram_we_n` both low for exactly the write-pulse length, with the request's byte on `sram_dq`. The memory stores that byte at the request's address.
- R4: `sram_oe_n` is low only in the read-access phase and never while `sram_we_n` is low. The controller drives `sram_dq` only while `sram_we_n` is low.
- R5: Read data is sampled from `sram_dq` on the edge that ends the read-access phase. In the next cycle, `rsp_valid` is 1 for exactly one cycle and `rsp_rdata` holds the sampled byte.
- R6: `req_ready` goes low on the cycle after acceptance. It stays low for pulse+recovery cycles after a write and for access+hold cycles after a read.
- R7: Changes to `req_valid`, `req_write`, `req_addr` and `req_wdata` while `req_ready` is low have no effect on the access in progress. The address and stored data are those captured at acceptance.
- R8: If `req_valid` stays high, the next request is accepted on the first cycle `req_ready` is high, with no idle gap.
- R9: All 17 address bits of an accepted request appear on `sram_addr` and stay stable while `sram_cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse: read data available |
| rsp_rdata | output | 8 | Byte read |
| sram_addr | output | 17 | Memory address pins |
| sram_cs_n | output | 1 | Memory chip select, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_dq | inout | 8 | Shared data bus |

## Verification
The bench sets the period parameter to 4000 ps so that every phase spans several cycles. Its memory model returns a poison byte until the access time has elapsed, so a controller that samples one cycle early returns wrong data instead of silently passing. Strobe-width monitors would catch a pulse or access counter off by one, and a busy-time check would catch a recovery or hold phase that was skipped. The bench scrambles the request fields right after acceptance, so a design that reads the live inputs instead of the captured ones writes the wrong address or byte. A contention monitor flags any cycle where output enable and write enable are low together, which is what a controller that turned the bus around too early would produce.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_PULSE,
        ST_WR_RECOV,
        ST_RD_ACCESS,
        ST_RD_HOLD
    } ctl_state_t;

    // cycles needed to cover t_ps at period p_ps, at least one
    function automatic int cycles_for(input int t_ps, input int p_ps);
        int c;
        c = (t_ps + p_ps - 1) / p_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_counter.sv
module sram_phase_counter #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    output logic [AW-1:0] held_addr,
    output logic [DW-1:0] held_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_addr <= '0;
            held_data <= '0;
        end else if (take) begin
            held_addr <= in_addr;
            held_data <= in_data;
        end
    end
endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] bus_in,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= capture;
            if (capture)
                out_data <= bus_in;
        end
    end
endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW         = 17,
    parameter int DW         = 8,
    parameter int CLK_PS     = 20000,
    parameter int T_WPULSE   = 12000,
    parameter int T_DSETUP   = 8000,
    parameter int T_WRECOV   = 2000,
    parameter int T_WCYCLE   = 15000,
    parameter int T_RACCESS  = 15000,
    parameter int T_RELEASE  = 8000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] sram_addr,
    output logic          sram_cs_n,
    output logic          sram_we_n,
    output logic          sram_oe_n,
    inout  wire  [DW-1:0] sram_dq
);
    localparam int N_WP = max2(cycles_for(T_WPULSE, CLK_PS), cycles_for(T_DSETUP, CLK_PS));
    localparam int N_WR = max2(max2(cycles_for(T_WRECOV, CLK_PS),
                                    cycles_for(T_WCYCLE, CLK_PS) - N_WP), 1);
    localparam int N_RA = cycles_for(T_RACCESS, CLK_PS);
    localparam int N_RH = cycles_for(T_RELEASE, CLK_PS);
    localparam int N_MAX = max2(max2(N_WP, N_WR), max2(N_RA, N_RH));
    localparam int CW = $clog2(N_MAX + 1);

    ctl_state_t    state, state_nxt;
    logic          ph_load, ph_last, accept, capture, drive_en;
    logic [CW-1:0] ph_val;
    logic [DW-1:0] held_data;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        ph_load   = 1'b0;
        ph_val    = '0;
        accept    = 1'b0;
        capture   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    accept  = 1'b1;
                    ph_load = 1'b1;
                    if (req_write) begin
                        state_nxt = ST_WR_PULSE;
                        ph_val    = CW'(N_WP - 1);
                    end else begin
                        state_nxt = ST_RD_ACCESS;
                        ph_val    = CW'(N_RA - 1);
                    end
                end
            end
            ST_WR_PULSE: begin
                if (ph_last) begin
                    state_nxt = ST_WR_RECOV;
                    ph_load   = 1'b1;
                    ph_val    = CW'(N_WR - 1);
                end
            end
            ST_WR_RECOV: begin
                if (ph_last)
                    state_nxt = ST_IDLE;
            end
            ST_RD_ACCESS: begin
                if (ph_last) begin
                    capture   = 1'b1;
                    state_nxt = ST_RD_HOLD;
                    ph_load   = 1'b1;
                    ph_val    = CW'(N_RH - 1);
                end
            end
            ST_RD_HOLD: begin
                if (ph_last)
                    state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // pin outputs
    always_comb begin
        req_ready = 1'b0;
        sram_cs_n = 1'b1;
        sram_we_n = 1'b1;
        sram_oe_n = 1'b1;
        drive_en  = 1'b0;
        unique case (state)
            ST_IDLE:      req_ready = 1'b1;
            ST_WR_PULSE: begin
                sram_cs_n = 1'b0;
                sram_we_n = 1'b0;
                drive_en  = 1'b1;
            end
            ST_RD_ACCESS: begin
                sram_cs_n = 1'b0;
                sram_oe_n = 1'b0;
            end
            ST_WR_RECOV, ST_RD_HOLD: ;
            default: ;
        endcase
    end

    assign sram_dq = drive_en ? held_data : {DW{1'bz}};

    sram_phase_counter #(.CW(CW)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .last     (ph_last)
    );

    sram_req_latch #(.AW(AW), .DW(DW)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (accept),
        .in_addr   (req_addr),
        .in_data   (req_wdata),
        .held_addr (sram_addr),
        .held_data (held_data)
    );

    sram_read_capture #(.DW(DW)) u_rcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .bus_in    (sram_dq),
        .out_valid (rsp_valid),
        .out_data  (rsp_rdata)
    );
endmodule

// File: rtl/sram_port_ctrl_chk.sv
module sram_port_ctrl_chk #(
    parameter int AW = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] sram_addr,
    input logic          sram_cs_n,
    input logic          sram_we_n,
    input logic          sram_oe_n
);
    // R4
    oe_we_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n);

    // R3
    we_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> !sram_cs_n);

    // R5
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_cs_n && sram_we_n && sram_oe_n));
endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .sram_addr (sram_addr),
    .sram_cs_n (sram_cs_n),
    .sram_we_n (sram_we_n),
    .sram_oe_n (sram_oe_n)
);

// File: tb/sram_port_ctrl_test.sv
`timescale 1ns/1ps
module sram_port_ctrl_test;
    localparam int PER = 4000;
    localparam int E_WP = 3, E_WR = 1, E_RA = 4, E_RH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rsp_valid, cs_n, we_n, oe_n;
    logic [7:0]  rsp_rdata;
    logic [16:0] sram_addr;
    wire  [7:0]  dq;

    int checks = 0, errors = 0;
    logic [7:0] mem [256];
    int  rd_age = 0;
    int  we_run = 0, rd_run = 0, rsp_cnt = 0;
    logic rsp_prev = 1'b0;
    logic [7:0] last_rd = '0;

    always #10 clk = ~clk;

    sram_port_ctrl #(.CLK_PS(PER)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
        .sram_cs_n(cs_n), .sram_we_n(we_n), .sram_oe_n(oe_n), .sram_dq(dq)
    );

    // memory model: poison byte until the access time has elapsed
    wire model_drv = !cs_n && we_n && !oe_n;
    assign dq = model_drv ? ((rd_age >= E_RA - 1) ? mem[sram_addr[7:0]] : 8'hEE) : 8'hzz;

    always @(posedge clk) begin
        if (model_drv) rd_age <= rd_age + 1;
        else           rd_age <= 0;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitors
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs_n && !we_n) mem[sram_addr[7:0]] = dq;
            if (!we_n) begin
                check(oe_n == 1'b1, "R4 oe low during write", oe_n, 1);
                we_run++;
            end else if (we_run != 0) begin
                check(we_run == E_WP, "R2 R3 write pulse cycles", we_run, E_WP);
                we_run = 0;
            end
            if (!cs_n && !oe_n) rd_run++;
            else if (rd_run != 0) begin
                check(rd_run == E_RA, "R2 read access cycles", rd_run, E_RA);
                rd_run = 0;
            end
            if (rsp_valid) begin
                check(!rsp_prev, "R5 rsp pulse width", 1, 0);
                rsp_cnt++;
                last_rd = rsp_rdata;
            end
            rsp_prev = rsp_valid;
        end
    end

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) ^ (i >> 3));
    endfunction

    function automatic logic [16:0] adr(input int i);
        return 17'(i) | (17'(i % 4) << 15) | (17'((i >> 2) % 8) << 10);
    endfunction

    task automatic xfer(input logic w, input logic [16:0] a, input logic [7:0] d,
                        output int busy);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        // R7: scramble inputs while busy
        req_valid = 1'b0; req_write = ~w; req_addr = ~a; req_wdata = ~d;
        // R9
        check(sram_addr == a, "R9 address pins", int'(sram_addr), int'(a));
        busy = 0;
        while (!req_ready) begin
            busy++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int busy, n0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        check({cs_n, we_n, oe_n} == 3'b111, "R1 strobes", {cs_n, we_n, oe_n}, 7);
        check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({cs_n, we_n, oe_n} == 3'b111, "R1 strobes after release", {cs_n, we_n, oe_n}, 7);

        // R3 R6: write sweep
        for (int i = 0; i < 256; i++) begin
            xfer(1'b1, adr(i), pat(i), busy);
            check(busy == E_WP + E_WR, "R6 write busy", busy, E_WP + E_WR);
            check(mem[i] == pat(i), "R3 R7 stored byte", mem[i], pat(i));
        end
        // R5 R6: read sweep
        for (int i = 0; i < 256; i++) begin
            n0 = rsp_cnt;
            xfer(1'b0, adr(i), 8'h00, busy);
            check(busy == E_RA + E_RH, "R6 read busy", busy, E_RA + E_RH);
            check(rsp_cnt == n0 + 1, "R5 one response", rsp_cnt - n0, 1);
            check(last_rd == pat(i), "R5 read data", last_rd, pat(i));
        end

        // R8: valid held across two writes
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h1_0005; req_wdata = 8'hA5;
        @(negedge clk);
        req_addr = 17'h0_8006; req_wdata = 8'h5A;
        busy = 0;
        while (!req_ready) begin busy++; @(negedge clk); end
        check(busy == E_WP + E_WR, "R8 first write busy", busy, E_WP + E_WR);
        @(negedge clk);
        check(req_ready == 1'b0 && we_n == 1'b0, "R8 second accepted at once", req_ready, 0);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        check(mem[5] == 8'hA5, "R8 first byte", mem[5], 8'hA5);
        check(mem[6] == 8'h5A, "R8 second byte", mem[6], 8'h5A);

        // R7: neighbours untouched by scrambled inputs
        xfer(1'b0, adr(7), 8'h00, busy);
        check(last_rd == pat(7), "R7 neighbour intact", last_rd, pat(7));
        // R4: read right after a write sees no contention (monitor), data correct
        xfer(1'b1, adr(9), 8'h3C, busy);
        xfer(1'b0, adr(9), 8'h00, busy);
        check(last_rd == 8'h3C, "R4 R5 turnaround read", last_rd, 8'h3C);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule